// File: doc/BRIEF.md
# Two-Wire Bus START/STOP Detector

This block watches the clock (SCL) and data (SDA) lines of a two-wire serial bus. It recognizes bus START and STOP conditions and keeps a bus-busy flag that other logic can read. Both lines first pass through a synchronizer. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Each condition counts only if SCL had been high long enough before the edge, SDA had been steady long enough before the edge, and both lines then stay put for a hold window after it.

Timing is counted in system clocks, and one clock stands for half of the bus reference cycle. This lets the half-cycle values of the timing rules be represented exactly.

A 5-bit setting S scales the windows in standard mode. In high-speed mode the windows are fixed and S is ignored. When a condition qualifies, the busy flag moves after a mode-dependent delay. A one-clock start or stop pulse marks the same clock.

Top module: `ssd_top`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `start_o` and `stop_o` are 0. After reset the block stays idle until a qualifying condition occurs.
- R2: A qualified START (SDA falling while SCL high) sets `busy_o` to 1. `start_o` is high for exactly the one clock on which the flag is updated.
- R3: A qualified STOP (SDA rising while SCL high) clears `busy_o` to 0. `stop_o` is high for exactly the one clock on which the flag is updated. `start_o` and `stop_o` are never high together.
- R4: In standard mode (`hs_mode_i`=0), the SDA edge is rejected unless the synchronized SCL has been high for at least 2*(S+1) clocks before it.
- R5: The edge is rejected unless SDA has held its previous level for at least S+1 clocks before it (standard) or 4 clocks before it (high-speed).
- R6: After the edge, SCL must stay high and SDA must keep its new level for S clocks (standard) or 4 clocks (high-speed), counting the edge clock. If either line changes earlier, the condition is dropped and `busy_o` keeps its value.
- R7: For a qualified condition, `busy_o` and the pulse change on the (D+3)-th rising clock edge after the raw SDA change, where D = S+3 (standard) or 7 (high-speed). There is no change and no pulse on the edge before.
- R8: In high-speed mode the required SCL-high time is fixed at 8 clocks, whatever the value of S.
- R9: An S of 0 or an odd S is used as the next even value (0 becomes 2, 31 becomes 32). For such a value, `ssc_err_o` is 1; for any nonzero even S it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one period equals half a bus reference cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| ssc_i | input | 5 | Timing setting S |
| hs_mode_i | input | 1 | 1 selects high-speed timing, 0 standard |
| busy_o | output | 1 | Bus-busy flag |
| start_o | output | 1 | One-clock pulse when a START updates the flag |
| stop_o | output | 1 | One-clock pulse when a STOP updates the flag |
| ssc_err_o | output | 1 | S is zero or odd |

## Verification
The state that matters is the pending-condition counter and its captured direction.

- If a pending condition is not cancelled when SCL drops or SDA reverts, it reaches `busy_o` and a pulse, D+3 clocks after the raw edge.
- An off-by-one in the release, setup or hold comparison shows the same way, one vector away from its boundary.
- A wrong delay moves the flag change by whole clocks, so the bench samples both the edge before the expected change and the edge of it.
- A wrong rounding of S shows up as an accepted edge one release step too early.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int unsigned SSC_W = 5;
  localparam int unsigned CNT_W = 7;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } ssd_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] rel;
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] hold;
    logic [CNT_W-1:0] dly;
  } ssd_thr_t;
endpackage

// File: rtl/ssd_sync.sv
module ssd_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;  // idle bus level
      else         chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/ssd_timing.sv
module ssd_timing
  import ssd_pkg::*;
#(
  parameter int unsigned HS_REL   = 8,
  parameter int unsigned HS_SETUP = 4,
  parameter int unsigned HS_HOLD  = 4,
  parameter int unsigned HS_DLY   = 7
) (
  input  logic [SSC_W-1:0] ssc_i,
  input  logic             hs_i,
  output ssd_thr_t         thr_o,
  output logic             err_o
);
  logic             bad;
  logic [CNT_W-1:0] s_eff;

  assign bad = (ssc_i == '0) || ssc_i[0];

  always_comb begin
    if (ssc_i == '0)  s_eff = CNT_W'(2);
    else if (ssc_i[0]) s_eff = CNT_W'(ssc_i) + CNT_W'(1);
    else               s_eff = CNT_W'(ssc_i);
  end

  always_comb begin
    if (hs_i) begin
      thr_o.rel   = CNT_W'(HS_REL);
      thr_o.setup = CNT_W'(HS_SETUP);
      thr_o.hold  = CNT_W'(HS_HOLD);
      thr_o.dly   = CNT_W'(HS_DLY);
    end else begin
      thr_o.rel   = (s_eff + CNT_W'(1)) << 1;
      thr_o.setup = s_eff + CNT_W'(1);
      thr_o.hold  = s_eff;
      thr_o.dly   = s_eff + CNT_W'(3);
    end
  end

  assign err_o = bad;
endmodule

// File: rtl/ssd_qual.sv
module ssd_qual
  import ssd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_s_i,
  input  logic     sda_s_i,
  input  ssd_thr_t thr_i,
  output logic     busy_o,
  output logic     start_o,
  output logic     stop_o
);
  ssd_state_e       state_q;
  logic             sda_q;
  logic             is_start_q;
  logic [CNT_W-1:0] scl_cnt_q, sda_cnt_q, pcnt_q;
  logic             sda_edge, qualify, broken;

  assign sda_edge = sda_s_i != sda_q;
  assign qualify  = (state_q == ST_IDLE) && sda_edge && scl_s_i &&
                    (scl_cnt_q >= thr_i.rel) && (sda_cnt_q >= thr_i.setup);
  // during hold: SCL dropped or SDA went back to its old level
  assign broken   = (pcnt_q < thr_i.hold) && (!scl_s_i || (sda_s_i == is_start_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q     <= 1'b1;
      scl_cnt_q <= '0;
      sda_cnt_q <= '0;
    end else begin
      sda_q <= sda_s_i;
      if (!scl_s_i)               scl_cnt_q <= '0;
      else if (scl_cnt_q != '1)   scl_cnt_q <= scl_cnt_q + CNT_W'(1);
      if (sda_edge)               sda_cnt_q <= CNT_W'(1);
      else if (sda_cnt_q != '1)   sda_cnt_q <= sda_cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      is_start_q <= 1'b0;
      pcnt_q     <= '0;
      busy_o     <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
    end else begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (qualify) begin
            state_q    <= ST_PEND;
            is_start_q <= ~sda_s_i;
            pcnt_q     <= CNT_W'(1);
          end
        end
        ST_PEND: begin
          if (broken) begin
            state_q <= ST_IDLE;
          end else if (pcnt_q >= thr_i.dly) begin
            state_q <= ST_IDLE;
            busy_o  <= is_start_q;
            start_o <= is_start_q;
            stop_o  <= ~is_start_q;
          end else begin
            pcnt_q <= pcnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssd_top.sv
module ssd_top
  import ssd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HS_REL      = 8,
  parameter int unsigned HS_SETUP    = 4,
  parameter int unsigned HS_HOLD     = 4,
  parameter int unsigned HS_DLY      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SSC_W-1:0] ssc_i,
  input  logic             hs_mode_i,
  output logic             busy_o,
  output logic             start_o,
  output logic             stop_o,
  output logic             ssc_err_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] lines_s;
  ssd_thr_t          thr;

  ssd_sync #(.STAGES(SYNC_STAGES), .W(NLINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  ssd_timing #(
    .HS_REL(HS_REL), .HS_SETUP(HS_SETUP), .HS_HOLD(HS_HOLD), .HS_DLY(HS_DLY)
  ) u_timing (
    .ssc_i(ssc_i),
    .hs_i (hs_mode_i),
    .thr_o(thr),
    .err_o(ssc_err_o)
  );

  ssd_qual u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_s_i(lines_s[1]),
    .sda_s_i(lines_s[0]),
    .thr_i  (thr),
    .busy_o (busy_o),
    .start_o(start_o),
    .stop_o (stop_o)
  );
endmodule

// File: rtl/ssd_chk.sv
module ssd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic start_o,
  input logic stop_o
);
  p_pulse_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o}));

  p_start_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);

  p_stop_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !busy_o);

  p_flag_moves_with_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o != $past(busy_o)) |-> (start_o || stop_o));

  p_start_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_stop_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
endmodule

bind ssd_top ssd_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_o (busy_o),
  .start_o(start_o),
  .stop_o (stop_o)
);

// File: tb/sim_ssd_top.sv
`timescale 1ns/1ps
module sim_ssd_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_i = 1'b1;
  logic       sda_i = 1'b1;
  logic [4:0] ssc_i = 5'd2;
  logic       hs_mode_i = 1'b0;
  logic       busy_o, start_o, stop_o, ssc_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit exp_busy = 0;

  always #2.5 clk_i = ~clk_i;

  ssd_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .ssc_i(ssc_i), .hs_mode_i(hs_mode_i), .busy_o(busy_o),
    .start_o(start_o), .stop_o(stop_o), .ssc_err_o(ssc_err_o)
  );

  // {hs, ssc, scl-high lead, is_start, hold length, expect fire}
  localparam int NV = 17;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 5'd2,  8'd6,  1'b1, 8'd20, 1'b1},
    {1'b0, 5'd2,  8'd6,  1'b0, 8'd20, 1'b1},
    {1'b0, 5'd2,  8'd5,  1'b1, 8'd20, 1'b0},
    {1'b0, 5'd2,  8'd6,  1'b1, 8'd1,  1'b0},
    {1'b0, 5'd2,  8'd6,  1'b1, 8'd2,  1'b1},
    {1'b0, 5'd18, 8'd38, 1'b0, 8'd30, 1'b1},
    {1'b0, 5'd18, 8'd37, 1'b1, 8'd30, 1'b0},
    {1'b0, 5'd18, 8'd38, 1'b1, 8'd17, 1'b0},
    {1'b0, 5'd7,  8'd18, 1'b1, 8'd30, 1'b1},
    {1'b0, 5'd7,  8'd17, 1'b0, 8'd30, 1'b0},
    {1'b0, 5'd0,  8'd6,  1'b0, 8'd20, 1'b1},
    {1'b1, 5'd18, 8'd8,  1'b1, 8'd20, 1'b1},
    {1'b1, 5'd18, 8'd7,  1'b0, 8'd20, 1'b0},
    {1'b1, 5'd2,  8'd8,  1'b0, 8'd3,  1'b0},
    {1'b1, 5'd2,  8'd8,  1'b0, 8'd4,  1'b1},
    {1'b1, 5'd31, 8'd8,  1'b1, 8'd20, 1'b1},
    {1'b0, 5'd31, 8'd66, 1'b0, 8'd40, 1'b1}
  };

  function automatic string tag_of(int i);
    case (i)
      2, 6, 9:   return "R4";
      3, 4, 7:   return "R6";
      8, 10, 16: return "R9";
      11, 12, 13, 14, 15: return "R8";
      1, 5:      return "R3";
      default:   return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dly_of(input bit hs, input logic [4:0] s);
    int se;
    se = (s == 0) ? 2 : (s[0] ? s + 1 : s);
    return hs ? 7 : se + 3;
  endfunction

  task automatic prep(input bit pre_sda);
    @(negedge clk_i); scl_i = 1'b0; sda_i = pre_sda;
    repeat (10) @(negedge clk_i);
  endtask

  // runs dly+4 negedges after the SDA edge and checks flag and pulses
  task automatic observe(input string req, input int dly, input int hold_len,
                         input bit fire, input bit st);
    int  stray = 0;
    bit  old = exp_busy;
    for (int n = 1; n <= dly + 4; n++) begin
      @(negedge clk_i);
      if (n == hold_len) scl_i = 1'b0;
      if (n == dly + 2) chk({req, " R7 early"}, busy_o, old);
      if (n == dly + 3) begin
        if (fire) exp_busy = st;
        chk({req, " R7 busy"}, busy_o, exp_busy);
        chk({req, " start pulse"}, start_o, fire && st);
        chk({req, " stop pulse"}, stop_o, fire && !st);
      end else if (start_o || stop_o) stray++;
    end
    chk({req, " stray pulse"}, stray, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset pulses", start_o | stop_o, 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    chk("R1 idle busy", busy_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v = VEC[i];
      bit hs = v[23];
      logic [4:0] s = v[22:18];
      int lead = int'(v[17:10]);
      bit st = v[9];
      int hl = int'(v[8:1]);
      bit fire = v[0];
      hs_mode_i = hs; ssc_i = s;
      prep(st);
      scl_i = 1'b1;
      repeat (lead) @(negedge clk_i);
      sda_i = ~st;
      observe(tag_of(i), dly_of(hs, s), hl, fire, st);
    end

    // R9 error flag
    ssc_i = 5'd0;  #1 chk("R9 err zero", ssc_err_o, 1);
    ssc_i = 5'd7;  #1 chk("R9 err odd", ssc_err_o, 1);
    ssc_i = 5'd18; #1 chk("R9 err even", ssc_err_o, 0);

    // R5 setup: aborted START then re-fall after 3 (reject) or 4 (accept) clocks, HS mode
    hs_mode_i = 1'b1;
    for (int d = 3; d <= 4; d++) begin
      prep(1'b1);
      scl_i = 1'b1;
      repeat (10) @(negedge clk_i);
      sda_i = 1'b0;
      @(negedge clk_i); sda_i = 1'b1;  // revert inside hold window (R6)
      repeat (d) @(negedge clk_i);
      sda_i = 1'b0;
      observe("R5", 7, 1000, d == 4, 1'b1);
    end

    // R1 reset while busy
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 reset clears busy", busy_o, 0);
    rst_ni = 1'b1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule